// File: doc/BRIEF.md
# Multi-Channel Serial Time-Slot Formatter

This block turns the I and Q sample words of several channels into a single serial bit stream. Each channel runs its own sequence of up to seven time slots. An 8-bit descriptor per slot sets what the slot carries (I, Q or zeros), how many bits it lasts, and whether a one-clock sync pulse goes with it. A per-channel start delay, counted in serial clocks, pushes the channel's frame later. With it, several channels can be lined up one after another on the same wire.

All channels watch one frame-start input. When it is seen, each channel takes a copy of its sample words and counts off its delay. It then sends its slots back to back, most significant bit first, until it reaches an all-zero descriptor or runs out of slots. A per-channel route-enable bit gates the channel onto the shared line, where the outputs of all enabled channels are ORed. A zero slot of one channel therefore never disturbs a data slot of another. A 2-bit placement field per channel sets where the sync pulse sits relative to its slot.

Top module: `serial_slot_fmt`

## Requirements
- R1: While reset is high and in the cycles after it, before any frame start, `ser_data` and `ser_sync` are 0.
- R2: A descriptor is decoded as follows:
  - Bits 2:0 are the kind: 1 is I, 2 is Q, and any other value sends zeros.
  - Bits 6:3 are a length code L. For L of 2 to 9 the slot is 4*(L-1) bits long. For L above 9 it is 32 bits long. For L of 0 or 1 it is 4 bits long.
  - Bit 7 asks for a sync pulse.
  - For example, 0xC9 is a 32-bit I slot with sync, and 0x4A is a 32-bit Q slot without sync.
- R3: A data slot sends the bits of its sample word most significant bit first. A slot shorter than the word sends only the top bits of the word.
- R4: With start delay D, the first bit of slot 1 is on the output in the (D+1)-th cycle after the rising edge that samples `frame_start` high.
- R5: Slots follow each other with no gap, in order from slot 1 to slot 7. Slot n (n = 1 to 4) is in `slot_cfg_lo` bits 8n-1:8n-8. Slots 5, 6 and 7 are in `slot_cfg_hi` bits 7:0, 15:8 and 23:16.
- R6: A frame ends at the first all-zero descriptor, or after slot 7. The channel outputs 0 from then on, and descriptors after the zero one have no effect.
- R7: The placement field sets where a slot's sync pulse falls:
  - 0: on the slot's first bit.
  - 1: one cycle before the first bit.
  - 2: on the last bit.
  - 3: one cycle after the last bit.
- R8: Each sync pulse lasts one cycle. A placement of 1 on slot 1 of a frame with delay 0 produces no pulse.
- R9: The sample words are captured on the frame-start edge. Changes to `i_data` and `q_data` during a frame do not change the bits that frame sends.
- R10: A channel with its route-enable bit at 0 adds nothing to `ser_data` or `ser_sync`. The outputs of all enabled channels are ORed onto the shared line.
- R11: A frame start that arrives during a frame abandons that frame and starts the new one at once, with the R4 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that starts a frame on all channels |
| i_data | input | NCH*DW | I sample words, channel c in bits c*DW +: DW |
| q_data | input | NCH*DW | Q sample words, channel c in bits c*DW +: DW |
| slot_cfg_lo | input | NCH*32 | Descriptors of slots 1 to 4, 8 bits per slot, channel c in bits c*32 +: 32 |
| slot_cfg_hi | input | NCH*24 | Descriptors of slots 5 to 7, 8 bits per slot, channel c in bits c*24 +: 24 |
| start_delay | input | NCH*12 | Start delay in clocks, channel c in bits c*12 +: 12 |
| sync_place | input | NCH*2 | Sync placement code, channel c in bits c*2 +: 2 |
| route_en | input | NCH | Per-channel enable onto the shared line |
| ser_data | output | 1 | Shared serial data line |
| ser_sync | output | 1 | Shared sync pulse line |

## Verification
Stream position k is the k-th cycle after the edge that samples `frame_start`, counted from 0. Bit p of a channel's frame is due at position D+p. The data line and the sync pulses for placements 0, 1 and 2 come from registers through gates only, so they are due in that same cycle. Placement 3 passes through one more register and is due the cycle after the slot's last bit. The bench drives and samples on falling edges. It lowers `frame_start` and reads position 0 on the first falling edge after the sampling edge. It then compares every later position against a stream model built from the descriptors, the delays and the words it drove during the start cycle.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    localparam int SLOTS  = 7;
    localparam int DESC_W = 8;
    localparam int DLY_W  = 12;

    typedef enum logic [2:0] {
        KIND_ZERO = 3'd0,
        KIND_I    = 3'd1,
        KIND_Q    = 3'd2
    } slot_kind_e;

    typedef struct packed {
        logic       sync_en;
        logic [3:0] len_code;
        logic [2:0] kind;
    } slot_desc_t;

    typedef enum logic [1:0] {
        SYNC_ON_FIRST  = 2'd0,
        SYNC_BEFORE    = 2'd1,
        SYNC_ON_LAST   = 2'd2,
        SYNC_AFTER     = 2'd3
    } sync_place_e;

    // Slot length in bits from the length code, clamped to the word width.
    function automatic int unsigned slot_len(input logic [3:0] code,
                                             input int unsigned maxlen);
        int unsigned n;
        if (code < 4'd2) n = 32'd4;
        else             n = (32'(code) << 2) - 32'd4;
        if (n > maxlen)  n = maxlen;
        return n;
    endfunction

endpackage

// File: rtl/slot_seq.sv
module slot_seq
    import fmt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      frame_start,
    input  logic [DW-1:0]             i_word,
    input  logic [DW-1:0]             q_word,
    input  logic [SLOTS*DESC_W-1:0]   descs,
    input  logic [DLY_W-1:0]          delay,
    input  logic [1:0]                sync_pos,
    output logic                      bit_out,
    output logic                      sync_out
);

    localparam int BW = $clog2(DW + 1);
    localparam int SW = $clog2(SLOTS + 1);

    slot_desc_t tbl [0:SLOTS+1];

    for (genvar g = 0; g < SLOTS + 2; g++) begin : g_tbl
        if (g < SLOTS) begin : g_used
            assign tbl[g] = slot_desc_t'(descs[g*DESC_W +: DESC_W]);
        end else begin : g_pad
            assign tbl[g] = '0;
        end
    end

    logic              active;
    logic [DLY_W-1:0]  dly_cnt;
    logic [SW-1:0]     slot;
    logic [BW-1:0]     bit_idx;
    logic [DW-1:0]     i_lat, q_lat;
    logic              late_sync;

    slot_desc_t        cur, nxt;
    logic [BW-1:0]     cur_len;
    logic              in_slot, last_bit;
    logic [DW-1:0]     word, shf;
    logic [SW:0]       nxt_idx;

    assign nxt_idx  = {1'b0, slot} + 1'b1;
    assign cur      = tbl[slot];
    assign nxt      = tbl[nxt_idx];
    assign cur_len  = BW'(slot_len(cur.len_code, DW));
    assign in_slot  = active && (dly_cnt == '0) && (cur != '0);
    assign last_bit = in_slot && (bit_idx == cur_len - 1'b1);

    always_comb begin
        case (slot_kind_e'(cur.kind))
            KIND_I:  word = i_lat;
            KIND_Q:  word = q_lat;
            default: word = '0;
        endcase
    end

    assign shf     = word << bit_idx;
    assign bit_out = in_slot & shf[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            dly_cnt   <= '0;
            slot      <= '0;
            bit_idx   <= '0;
            i_lat     <= '0;
            q_lat     <= '0;
            late_sync <= 1'b0;
        end else begin
            late_sync <= last_bit && cur.sync_en;
            if (frame_start) begin
                active  <= 1'b1;
                dly_cnt <= delay;
                slot    <= '0;
                bit_idx <= '0;
                i_lat   <= i_word;
                q_lat   <= q_word;
            end else if (active) begin
                if (dly_cnt != '0) begin
                    dly_cnt <= dly_cnt - 1'b1;
                end else if (cur == '0) begin
                    active <= 1'b0;
                end else if (last_bit) begin
                    bit_idx <= '0;
                    slot    <= slot + 1'b1;
                    if (nxt == '0) active <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (sync_place_e'(sync_pos))
            SYNC_ON_FIRST: sync_out = in_slot && (bit_idx == '0) && cur.sync_en;
            SYNC_BEFORE:   sync_out = (active && (dly_cnt == DLY_W'(1)) && (cur != '0) && cur.sync_en)
                                   || (last_bit && (nxt != '0) && nxt.sync_en);
            SYNC_ON_LAST:  sync_out = last_bit && cur.sync_en;
            default:       sync_out = late_sync;
        endcase
    end

    // R1: reset leaves the channel idle
    assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !active && !late_sync);

    // R2: bit counter stays inside the decoded slot length
    assert_bit_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        in_slot |-> (bit_idx < cur_len));

    // R4: delay counts down one per clock
    assert_delay_count_R4: assert property (@(posedge clk) disable iff (rst)
        (active && (dly_cnt != '0) && !frame_start) |=> (dly_cnt == $past(dly_cnt) - 1'b1));

    // R6: a zero descriptor closes the frame
    assert_end_on_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (active && (dly_cnt == '0) && (cur == '0) && !frame_start) |=> !active);

    // R8: sync pulses of one channel never run two cycles
    assert_sync_single_R8: assert property (@(posedge clk) disable iff (rst)
        (sync_out && !frame_start) |=> !sync_out);

    // R9: captured words hold for the whole frame
    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (active && !frame_start) |=> ($stable(i_lat) && $stable(q_lat)));

endmodule

// File: rtl/ser_merge.sv
module ser_merge #(
    parameter int NCH = 2
) (
    input  logic [NCH-1:0] ch_bits,
    input  logic [NCH-1:0] ch_syncs,
    input  logic [NCH-1:0] enables,
    output logic           line_data,
    output logic           line_sync
);

    assign line_data = |(ch_bits  & enables);
    assign line_sync = |(ch_syncs & enables);

endmodule

// File: rtl/serial_slot_fmt.sv
module serial_slot_fmt
    import fmt_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic [NCH*DW-1:0]    i_data,
    input  logic [NCH*DW-1:0]    q_data,
    input  logic [NCH*32-1:0]    slot_cfg_lo,
    input  logic [NCH*24-1:0]    slot_cfg_hi,
    input  logic [NCH*12-1:0]    start_delay,
    input  logic [NCH*2-1:0]     sync_place,
    input  logic [NCH-1:0]       route_en,
    output logic                 ser_data,
    output logic                 ser_sync
);

    localparam int DESCS_W = SLOTS * DESC_W;

    logic [NCH-1:0] ch_bits;
    logic [NCH-1:0] ch_syncs;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [DESCS_W-1:0] descs;
        assign descs = {slot_cfg_hi[c*24 +: 24], slot_cfg_lo[c*32 +: 32]};

        slot_seq #(.DW(DW)) i_seq (
            .clk         (clk),
            .rst         (rst),
            .frame_start (frame_start),
            .i_word      (i_data[c*DW +: DW]),
            .q_word      (q_data[c*DW +: DW]),
            .descs       (descs),
            .delay       (start_delay[c*DLY_W +: DLY_W]),
            .sync_pos    (sync_place[c*2 +: 2]),
            .bit_out     (ch_bits[c]),
            .sync_out    (ch_syncs[c])
        );
    end

    ser_merge #(.NCH(NCH)) i_merge (
        .ch_bits   (ch_bits),
        .ch_syncs  (ch_syncs),
        .enables   (route_en),
        .line_data (ser_data),
        .line_sync (ser_sync)
    );

    // R10: with no channel routed the shared line stays quiet
    assert_route_off_R10: assert property (@(posedge clk) disable iff (rst)
        (route_en == '0) |-> (!ser_data && !ser_sync));

endmodule

// File: tb/test_serial_slot_fmt.sv
module test_serial_slot_fmt;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0;
    logic [NCH*DW-1:0] i_data = '0;
    logic [NCH*DW-1:0] q_data = '0;
    logic [NCH*32-1:0] slot_cfg_lo = '0;
    logic [NCH*24-1:0] slot_cfg_hi = '0;
    logic [NCH*12-1:0] start_delay = '0;
    logic [NCH*2-1:0]  sync_place = '0;
    logic [NCH-1:0]    route_en = '0;
    logic              ser_data;
    logic              ser_sync;

    serial_slot_fmt #(.NCH(NCH), .DW(DW)) i_serial_slot_fmt (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .i_data(i_data), .q_data(q_data),
        .slot_cfg_lo(slot_cfg_lo), .slot_cfg_hi(slot_cfg_hi),
        .start_delay(start_delay), .sync_place(sync_place),
        .route_en(route_en), .ser_data(ser_data), .ser_sync(ser_sync)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [55:0] dsc [NCH];
    int          dly [NCH];
    logic [1:0]  sp  [NCH];
    logic        en  [NCH];
    logic [31:0] iw  [NCH];
    logic [31:0] qw  [NCH];

    int checks = 0;
    int failures = 0;
    bit done = 0;

    function automatic int blen(input logic [3:0] code);
        int n;
        n = (code < 2) ? 4 : 4 * (int'(code) - 1);
        return (n > DW) ? DW : n;
    endfunction

    function automatic logic exp_bit(input int c, input int k);
        int pos;
        pos = k - dly[c];
        if (pos < 0) return 1'b0;
        for (int s = 0; s < 7; s++) begin
            logic [7:0] d;
            int L;
            logic [31:0] w;
            d = dsc[c][8*s +: 8];
            if (d == 8'h00) return 1'b0;
            L = blen(d[6:3]);
            if (pos < L) begin
                w = (d[2:0] == 3'd1) ? iw[c] : (d[2:0] == 3'd2) ? qw[c] : 32'h0;
                return w[31 - pos];
            end
            pos -= L;
        end
        return 1'b0;
    endfunction

    function automatic logic exp_sync(input int c, input int k);
        int start;
        logic hit;
        start = dly[c];
        hit = 1'b0;
        for (int s = 0; s < 7; s++) begin
            logic [7:0] d;
            int L;
            d = dsc[c][8*s +: 8];
            if (d == 8'h00) break;
            L = blen(d[6:3]);
            if (d[7]) begin
                case (sp[c])
                    2'd0: if (k == start)         hit = 1'b1;
                    2'd1: if (k == start - 1)     hit = 1'b1;
                    2'd2: if (k == start + L - 1) hit = 1'b1;
                    default: if (k == start + L)  hit = 1'b1;
                endcase
            end
            start += L;
        end
        return hit;
    endfunction

    function automatic int frame_len();
        int m;
        m = 0;
        for (int c = 0; c < NCH; c++) begin
            int t;
            t = dly[c];
            for (int s = 0; s < 7; s++) begin
                if (dsc[c][8*s +: 8] == 8'h00) break;
                t += blen(dsc[c][8*s+3 +: 4]);
            end
            if (t > m) m = t;
        end
        return m + 2;
    endfunction

    task automatic chk(input string req, input string what, input int k,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s pos %0d actual=%b expected=%b", req, what, k, act, exp);
        end
    endtask

    task automatic apply_cfg();
        for (int c = 0; c < NCH; c++) begin
            slot_cfg_lo[c*32 +: 32] = dsc[c][31:0];
            slot_cfg_hi[c*24 +: 24] = dsc[c][55:32];
            start_delay[c*12 +: 12] = 12'(dly[c]);
            sync_place[c*2 +: 2]    = sp[c];
            route_en[c]             = en[c];
        end
    endtask

    // Called at a falling edge: pulses frame_start, then checks positions.
    task automatic run_frame(input string req, input int stop_after);
        int n;
        apply_cfg();
        for (int c = 0; c < NCH; c++) begin
            iw[c] = $urandom;
            qw[c] = $urandom;
            i_data[c*DW +: DW] = iw[c];
            q_data[c*DW +: DW] = qw[c];
        end
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        i_data = {$urandom, $urandom};
        q_data = {$urandom, $urandom};
        n = frame_len();
        if (stop_after > 0 && stop_after < n) n = stop_after;
        for (int k = 0; k < n; k++) begin
            logic ed, es;
            ed = 1'b0;
            es = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                if (en[c]) begin
                    ed |= exp_bit(c, k);
                    es |= exp_sync(c, k);
                end
            end
            chk(req, "data", k, ser_data, ed);
            chk(req, "sync", k, ser_sync, es);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic clear_cfg();
        for (int c = 0; c < NCH; c++) begin
            dsc[c] = '0; dly[c] = 0; sp[c] = 2'd0; en[c] = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0A1B));
        clear_cfg();
        apply_cfg();
        @(negedge clk);
        chk("R1", "data in reset", 0, ser_data, 1'b0);
        chk("R1", "sync in reset", 0, ser_sync, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R1", "data idle", k, ser_data, 1'b0);
            chk("R1", "sync idle", k, ser_sync, 1'b0);
            @(negedge clk);
        end

        // Two channels, I then Q, second delayed by 64 (R4, R5, R9)
        clear_cfg();
        dsc[0] = 56'h4AC9; dsc[1] = 56'h4AC9; dly[1] = 64;
        run_frame("R4/R5/R9", 0);
        repeat (2) @(negedge clk);

        // Second channel switched off the shared line (R10)
        en[1] = 1'b0;
        run_frame("R10", 0);
        repeat (2) @(negedge clk);
        en[0] = 1'b0;
        run_frame("R10", 0);
        repeat (2) @(negedge clk);

        // Sync placements (R7, R8)
        for (int p = 0; p < 4; p++) begin
            clear_cfg();
            dsc[0] = 56'h8A_11_C9; sp[0] = 2'(p);
            dsc[1] = 56'hCA_00_00_00_00_00; dly[1] = (p == 1) ? 0 : 3; sp[1] = 2'(p);
            run_frame("R7/R8", 0);
            repeat (2) @(negedge clk);
        end
        clear_cfg();
        dsc[0] = 56'hC9; sp[0] = 2'd1; en[1] = 1'b0;
        run_frame("R8", 0);
        repeat (2) @(negedge clk);

        // Length codes, short slots and non-data kinds (R2, R3)
        clear_cfg();
        dsc[0] = 56'h7F_2A_99_FB_1A_02_81; dly[0] = 5;
        dsc[1] = 56'h5E_4C_03_BA_31_8A_29; dly[1] = 1; sp[1] = 2'd2;
        run_frame("R2/R3", 0);
        repeat (2) @(negedge clk);

        // Frame end: all seven slots, and a zero descriptor mid-table (R6)
        clear_cfg();
        dsc[0] = 56'h91_8A_0B_89_12_09_C9; dly[0] = 2; sp[0] = 2'd3;
        dsc[1] = 56'hC9_4A_C9_00_4A_C9_11; dly[1] = 7;
        run_frame("R6", 0);
        repeat (2) @(negedge clk);

        // Restart during a frame (R11)
        clear_cfg();
        dsc[0] = 56'h4AC9; dsc[1] = 56'h4A_0A_C9; dly[1] = 9;
        run_frame("R11", 20);
        run_frame("R11", 0);
        repeat (2) @(negedge clk);

        // Constrained random frames (R3, R5, R9)
        for (int f = 0; f < 40; f++) begin
            for (int c = 0; c < NCH; c++) begin
                int n;
                n = 1 + int'($urandom % 7);
                dsc[c] = '0;
                for (int s = 0; s < 7; s++) begin
                    if (s < n) begin
                        logic [7:0] d;
                        d = 8'($urandom);
                        if (d == 8'h00) d = 8'h11;
                        dsc[c][8*s +: 8] = d;
                    end
                end
                dly[c] = int'($urandom % 80);
                sp[c]  = 2'($urandom);
                en[c]  = ($urandom % 4) != 0;
            end
            run_frame("R3/R5/R9", 0);
            repeat (3) @(negedge clk);
        end

        finish_run();
    end

endmodule